// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent up-counting timers that share one simple register bus. Each channel picks its count clock: either every cycle of the block clock, or rising edges seen on its own external input after synchronization. That clock can be slowed by a power-of-two divider. The counter runs freely and wraps at the top of its width. In interval mode it instead returns to zero after reaching a programmed limit. Each of these events sets a pending flag. A pending flag can raise the channel's interrupt line, and reading the status register clears the flags.

Software sets a channel up while it is stopped. A single control write then restarts the count from zero and sets the mode, so the first interval has an exact length. The interrupt handler acknowledges the event by reading the status register.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, every clock-control, counter-control, interval, status and enable register reads 0, and all interrupt outputs are low.
- R2: Channel c's registers sit at group base + 4*c. The group bases are clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54 and enable 0x60. Any other address reads 0. Read data appears on the cycle after the read strobe.
- R3: When prescaling is off and the internal clock is selected, a running counter advances by one on every clock edge.
- R4: In clock control, bit 0 enables the divider and bits 4:1 hold an exponent N. With the divider on, the count advances once every 2^(N+1) base pulses, and the first advance comes 2^(N+1) pulses after a restart.
- R5: When clock-control bit 5 is 1, each rising edge on the channel's external input counts as one base pulse, after synchronization. A static input leaves the count unchanged.
- R6: While counter-control bit 0 is 1, the count value holds.
- R7: Writing 1 to counter-control bit 4 sets the count and the divider to 0 on that write. The bit always reads back as 0.
- R8: When counter-control bit 1 is 1 (interval mode), the count goes to 0 on the advance after it equals the interval register, and status bit 0 is set. One period is therefore (interval+1) advances.
- R9: Outside interval mode, an advance from the all-ones count wraps to 0 and sets status bit 1.
- R10: A status read returns the pending flags and clears them. An event in the same cycle as the read stays pending.
- R11: A channel's interrupt output equals the OR of its status bits ANDed with enable bits 1:0. It updates in the same cycle as the status register.
- R12: Unused bits read as 0. The interval register keeps only the counter width. Writes to the count and status registers have no effect.
- R13: Activity on one channel does not change another channel's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_clk | input | NUM_CH | Per-channel external count input, asynchronous |
| irq | output | NUM_CH | Per-channel registered interrupt |

## Verification
The bench builds the block with its defaults: three channels, a 16-bit counter and an 8-bit address. The 16-bit width keeps a full wrap to about 65 thousand cycles. This lets the bench measure the exact cycle of a real overflow event and read back the truncated interval register. Having all three channels lets it check the address stride and show that channels stay independent. Small divider exponents (0 and 2) confirm the 2^(N+1) period formula without long waits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BUS_W   = 32;
  localparam int PSV_W   = 4;
  localparam int STS_W   = 2;
  localparam int NUM_GRP = 6;

  // group base offsets, index order matches regsel_t minus one
  localparam logic [7:0] GRP_BASE [NUM_GRP] =
    '{8'h00, 8'h0C, 8'h18, 8'h24, 8'h54, 8'h60};

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CLK  = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_VAL  = 3'd3,
    SEL_INT  = 3'd4,
    SEL_STS  = 3'd5,
    SEL_IEN  = 3'd6
  } regsel_t;

  typedef struct packed {
    logic             src_ext;  // bit 5
    logic [PSV_W-1:0] psv;      // bits 4:1
    logic             pre_en;   // bit 0
  } clkctl_t;

  typedef struct packed {
    logic mode_int;  // bit 1
    logic stop;      // bit 0
  } cntctl_t;

  localparam int RESTART_BIT = 4;

endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ext_i};
      last_q <= sync_q[STAGES-1];
      rise_o <= sync_q[STAGES-1] & ~last_q;
    end
  end

  p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PW = PSV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          base_i,
  input  logic          en_i,
  input  logic          pre_en_i,
  input  logic [PW-1:0] psv_i,
  output logic          tick_o
);

  localparam int PRE_W = 2 ** PW;
  localparam logic [PRE_W:0] ONE = 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   mask_full;
  logic [PRE_W-1:0] mask;
  logic             step;

  assign mask_full = (ONE << ({1'b0, psv_i} + (PW+1)'(1))) - ONE;
  assign mask      = mask_full[PRE_W-1:0];
  assign step      = base_i & en_i;
  assign tick_o    = step & (~pre_en_i | ((pre_q & mask) == mask));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pre_q <= '0;
    end else if (step && pre_en_i) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  p_tick_needs_base_r4: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (base_i && en_i));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pre_q == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             rd_i,
  input  regsel_t          sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             ext_rise_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o
);

  clkctl_t          clk_q;
  cntctl_t          ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ival_q;
  logic [STS_W-1:0] sts_q;
  logic [STS_W-1:0] ien_q;

  logic             wr_clk, wr_ctl, wr_int, wr_ien, rd_sts;
  logic             restart, base, tick, run, match, wrap;
  logic [STS_W-1:0] ev, sts_nxt, ien_nxt;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign wr_clk  = wr_i && (sel_i == SEL_CLK);
  assign wr_ctl  = wr_i && (sel_i == SEL_CNT);
  assign wr_int  = wr_i && (sel_i == SEL_INT);
  assign wr_ien  = wr_i && (sel_i == SEL_IEN);
  assign rd_sts  = rd_i && (sel_i == SEL_STS);
  assign restart = wr_ctl && wdata_i[RESTART_BIT];

  assign base = clk_q.src_ext ? ext_rise_i : 1'b1;

  tmr_prescaler #(.PW(PSV_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (restart),
    .base_i   (base),
    .en_i     (~ctl_q.stop),
    .pre_en_i (clk_q.pre_en),
    .psv_i    (clk_q.psv),
    .tick_o   (tick)
  );

  assign run   = tick && !restart;
  assign match = run && ctl_q.mode_int && (cnt_q == ival_q);
  assign wrap  = run && !match && (cnt_q == {CNT_W{1'b1}});
  assign ev    = {wrap, match};

  assign sts_nxt = (rd_sts ? '0 : sts_q) | ev;
  assign ien_nxt = wr_ien ? wdata_i[STS_W-1:0] : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q  <= '0;
      ctl_q  <= '0;
      cnt_q  <= '0;
      ival_q <= '0;
      sts_q  <= '0;
      ien_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_clk) clk_q  <= clkctl_t'(wdata_i[$bits(clkctl_t)-1:0]);
      if (wr_ctl) ctl_q  <= cntctl_t'(wdata_i[$bits(cntctl_t)-1:0]);
      if (wr_int) ival_q <= wdata_i[CNT_W-1:0];
      if (restart)   cnt_q <= '0;
      else if (match) cnt_q <= '0;
      else if (run)   cnt_q <= cnt_q + CNT_W'(1);
      sts_q <= sts_nxt;
      ien_q <= ien_nxt;
      irq_o <= |(sts_nxt & ien_nxt);
    end
  end

  always_comb begin
    case (sel_i)
      SEL_CLK: rdata_o = BUS_W'(clk_q);
      SEL_CNT: rdata_o = BUS_W'(ctl_q);
      SEL_VAL: rdata_o = BUS_W'(cnt_q);
      SEL_INT: rdata_o = BUS_W'(ival_q);
      SEL_STS: rdata_o = BUS_W'(sts_q);
      SEL_IEN: rdata_o = BUS_W'(ien_q);
      default: rdata_o = '0;
    endcase
  end

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.stop && !restart) |=> (cnt_q == $past(cnt_q)));

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));

  p_match_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (run && ctl_q.mode_int && cnt_q == ival_q) |=> (cnt_q == '0 && sts_q[0]));

  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !ctl_q.mode_int && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0 && sts_q[1]));

  p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_sts && ev == '0) |=> (sts_q == '0));

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(sts_q & ien_q));

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] ext_clk,
  output logic [NUM_CH-1:0] irq
);

  regsel_t          sel_c  [NUM_CH];
  logic [31:0]      rd_c   [NUM_CH];
  logic [NUM_CH-1:0] hit;
  logic [31:0]      rd_mux;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      sel_c[c] = SEL_NONE;
      hit[c]   = 1'b0;
      for (int g = 0; g < NUM_GRP; g++) begin
        if (bus_addr == ADDR_W'(int'(GRP_BASE[g]) + 4 * c)) begin
          sel_c[c] = regsel_t'(3'(g + 1));
          hit[c]   = 1'b1;
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic rise;

    tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .ext_i  (ext_clk[c]),
      .rise_o (rise)
    );

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_i       (bus_wr),
      .rd_i       (bus_rd),
      .sel_i      (sel_c[c]),
      .wdata_i    (bus_wdata),
      .ext_rise_i (rise),
      .rdata_o    (rd_c[c]),
      .irq_o      (irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) rd_mux = rd_mux | rd_c[c];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  p_single_hit_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  p_idle_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit == '0) |=> (bus_rdata == '0));

endmodule

// File: tb/tri_interval_timer_tb.sv
module tri_interval_timer_tb;

  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NUM_CH-1:0] ext_clk = '0;
  logic [NUM_CH-1:0] irq;

  int n_chk  = 0;
  int n_fail = 0;

  tri_interval_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .irq(irq)
  );

  always #5 clk = ~clk;

  localparam logic [7:0] A_CLK = 8'h00, A_CTL = 8'h0C, A_VAL = 8'h18,
                         A_INT = 8'h24, A_STS = 8'h54, A_IEN = 8'h60;

  function automatic logic [7:0] ra(logic [7:0] base, int ch);
    return base + 8'(4 * ch);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_irq(int ch, int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (irq[ch]) begin k = i; break; end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic [7:0] bases [5] = '{A_CLK, A_CTL, A_INT, A_STS, A_IEN};
    check("R1 irq after reset", 32'(irq), 32'h0);
    for (int c = 0; c < NUM_CH; c++)
      for (int g = 0; g < 5; g++) begin
        rd(ra(bases[g], c), d);
        check($sformatf("R1 reg 0x%0h", ra(bases[g], c)), d, 32'h0);
      end
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(ra(A_INT, 2), 32'h1234);
    rd(8'h2C, d); check("R2 ch2 interval at 0x2C", d, 32'h1234);
    rd(8'h24, d); check("R2 ch0 interval untouched", d, 32'h0);
    rd(8'h28, d); check("R2 ch1 interval untouched", d, 32'h0);
    rd(8'h30, d); check("R2 unmapped 0x30", d, 32'h0);
    rd(8'h70, d); check("R2 unmapped 0x70", d, 32'h0);
    wr(ra(A_INT, 2), 32'h0);
  endtask

  task automatic t_unused;
    logic [31:0] a, d;
    wr(ra(A_CLK, 0), 32'hFFFF_FFFF);
    rd(ra(A_CLK, 0), d); check("R12 clock control bits", d, 32'h3F);
    wr(ra(A_CLK, 0), 32'h0);
    wr(ra(A_CTL, 0), 32'hFFFF_FFFF);
    rd(ra(A_CTL, 0), d); check("R12 R7 counter control readback", d, 32'h3);
    wr(ra(A_INT, 0), 32'hFFFF_FFFF);
    rd(ra(A_INT, 0), d); check("R12 interval width", d, 32'hFFFF);
    wr(ra(A_CTL, 0), 32'h1);
    rd(ra(A_VAL, 0), a);
    wr(ra(A_VAL, 0), 32'hABCD);
    rd(ra(A_VAL, 0), d); check("R12 count write ignored", d, 32'h0);
    wr(ra(A_STS, 0), 32'hFF);
    rd(ra(A_STS, 0), d); check("R12 status write ignored", d, 32'h0);
    wr(ra(A_IEN, 0), 32'hFF);
    rd(ra(A_IEN, 0), d); check("R12 enable bits", d, 32'h3);
    wr(ra(A_IEN, 0), 32'h0);
  endtask

  task automatic t_stop_restart;
    logic [31:0] a, b, d;
    wr(ra(A_CTL, 0), 32'h10);
    repeat (10) @(posedge clk);
    wr(ra(A_CTL, 0), 32'h1);
    rd(ra(A_VAL, 0), a); check("R3 count after 11 edges", a, 32'd11);
    repeat (10) @(posedge clk);
    rd(ra(A_VAL, 0), b); check("R6 count holds while stopped", b, a);
    wr(ra(A_CTL, 0), 32'h11);
    rd(ra(A_VAL, 0), d); check("R7 restart clears count", d, 32'h0);
    rd(ra(A_CTL, 0), d); check("R7 restart bit reads 0", d, 32'h1);
  endtask

  task automatic t_interval(int n_exp, int ival, int expk, string tag);
    int k;
    logic [31:0] d;
    wr(ra(A_CTL, 0), 32'h1);
    wr(ra(A_CLK, 0), 32'(((n_exp & 15) << 1) | 1));
    wr(ra(A_INT, 0), 32'(ival));
    wr(ra(A_IEN, 0), 32'h1);
    wr(ra(A_CTL, 0), 32'h12);
    wait_irq(0, 1000, k);
    check(tag, 32'(k), 32'(expk));
    wr(ra(A_CTL, 0), 32'h3);
    rd(ra(A_STS, 0), d); check("R8 interval flag is bit 0", d, 32'h1);
    wr(ra(A_IEN, 0), 32'h0);
    wr(ra(A_CLK, 0), 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] d, c0a, c0b;
    rd(ra(A_VAL, 0), c0a);
    wr(ra(A_INT, 1), 32'd2);
    wr(ra(A_CTL, 1), 32'h12);
    repeat (10) @(posedge clk); #1;
    check("R11 masked event keeps irq low", 32'(irq[1]), 32'h0);
    wr(ra(A_IEN, 1), 32'h1);
    check("R11 enabling raises irq", 32'(irq[1]), 32'h1);
    wr(ra(A_CTL, 1), 32'h3);
    rd(ra(A_STS, 1), d); check("R10 read returns pending", d, 32'h1);
    check("R11 irq drops after read", 32'(irq[1]), 32'h0);
    rd(ra(A_STS, 1), d); check("R10 second read empty", d, 32'h0);
    wr(ra(A_INT, 1), 32'd0);
    wr(ra(A_CTL, 1), 32'h12);
    repeat (3) @(posedge clk);
    rd(ra(A_STS, 1), d); check("R10 read with events", d, 32'h1);
    rd(ra(A_STS, 1), d); check("R10 same-cycle event kept", d, 32'h1);
    check("R10 irq stays with new event", 32'(irq[1]), 32'h1);
    check("R13 other irqs quiet", 32'({irq[2], irq[0]}), 32'h0);
    rd(ra(A_VAL, 0), c0b); check("R13 ch0 count undisturbed", c0b, c0a);
    wr(ra(A_CTL, 1), 32'h3);
    wr(ra(A_IEN, 1), 32'h0);
    rd(ra(A_STS, 1), d);
  endtask

  task automatic t_ext;
    logic [31:0] d;
    wr(ra(A_CLK, 2), 32'h20);
    wr(ra(A_CTL, 2), 32'h10);
    repeat (20) @(posedge clk);
    rd(ra(A_VAL, 2), d); check("R5 static input no count", d, 32'h0);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); ext_clk[2] = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk[2] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (8) @(posedge clk);
    rd(ra(A_VAL, 2), d); check("R5 three external edges", d, 32'd3);
  endtask

  task automatic t_wrap;
    int k;
    logic [31:0] d;
    wr(ra(A_CLK, 2), 32'h0);
    wr(ra(A_IEN, 2), 32'h2);
    wr(ra(A_CTL, 2), 32'h10);
    wait_irq(2, 70000, k);
    check("R9 wrap after 2^16 advances", 32'(k), 32'd65536);
    wr(ra(A_CTL, 2), 32'h1);
    rd(ra(A_STS, 2), d); check("R9 overflow flag is bit 1", d, 32'h2);
    check("R11 irq clear after read", 32'(irq[2]), 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_map();
    t_unused();
    t_stop_restart();
    t_interval(0, 5, 12, "R4 R8 N=0 interval 5 period");
    t_interval(2, 3, 32, "R4 R8 N=2 interval 3 period");
    t_status();
    t_ext();
    t_wrap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule